// File: doc/BRIEF.md
# PCM Frame-Sync Serial Port

This block is a serial port for 8-bit voice samples. A bit clock and a frame-sync input arrive from outside. Once per frame the block shifts one transmit word out and one receive word in, most significant bit first. The bit clock, the frame sync and the receive data are all sampled by the system clock through a short synchronizer. Clock edges are found inside the block, so all state sits in the system-clock domain.

The block works out the framing style from the width of each sync pulse. Its framing then uses the style measured on the previous pulse. In long framing the first bit goes out at the bit-clock rise that raises sync. In short framing the first bit goes out one bit period later. The serial output comes with a separate enable that stands in for a tri-state driver. After reset, or after a power-down request is released, the enable stays off for two whole frames so that the port cannot collide with another talker on a shared line.

Top module: `pcm_fsync_port`

## Requirements
- R1: After reset, `txd_oe_o`, `txd_o` and `rx_valid_o` are 0 and the first frame uses short framing. Reset also starts the two-frame output guard of R9.
- R2: A sync pulse seen high at exactly one bit-clock fall is classed short. A pulse high at two or more consecutive falls is classed long. The class takes effect for the frame that begins at the next sync rise.
- R3: In short framing the MSB is driven at the bit-clock rise that follows the fall that sampled sync high. `txd_oe_o` rises at that same rise. The remaining bits follow, one per rise, MSB first. The word sent is `tx_word_i` as held at that rise.
- R4: In short framing `txd_oe_o` drops at the bit-clock fall in the middle of the LSB period.
- R5: In long framing the MSB is driven at the bit-clock rise where sync rises. If sync is low at the fall in the middle of the LSB, `txd_oe_o` drops there. Otherwise it stays on until the first rise at which sync is low.
- R6: Receive bits are taken at bit-clock falls, MSB first, one at the fall of each transmit bit period. In short framing the first bit is the fall after the one that sampled sync. In long framing it is the fall after the sync rise.
- R7: Each received word appears on `rx_word_o` with a `rx_valid_o` pulse one system cycle wide. The pulse follows the eighth sample, and there is one pulse per frame.
- R8: While `pwrdn_i` is 1, `txd_oe_o` is 0 and `rx_valid_o` stays 0 from the next cycle on. Any word in progress is dropped.
- R9: After `pwrdn_i` falls, or after reset, the frames of the first two sync rises leave `txd_oe_o` at 0, though receive still works. The frame of the third sync rise transmits.
- R10: `txd_o` is 0 whenever `txd_oe_o` is 0. `txd_o` changes only one cycle after a bit-clock edge is detected or after power-down is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous to clk |
| fsync_i | input | 1 | Frame sync, changes with bit-clock rises |
| rxd_i | input | 1 | Serial receive data |
| pwrdn_i | input | 1 | Power-down request |
| tx_word_i | input | 8 | Word to send in the next frame |
| txd_o | output | 1 | Serial transmit data |
| txd_oe_o | output | 1 | Output enable for the transmit pin |
| rx_word_o | output | 8 | Last word received |
| rx_valid_o | output | 1 | One-cycle strobe when `rx_word_o` updates |

## Verification
The assertions take for granted that the bit clock runs slowly enough that each high and low phase spans several system cycles. They also assume that sync and receive data change only together with a bit-clock rise, so that all three pass through the synchronizer side by side. The bench meets both conditions by building every bit period from whole system cycles: eight high and eight low. It changes sync and data only on the cycle that raises the bit clock, and it leaves at least one sync-low period between frames. Power-down is raised and dropped only between frames.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int PCM_WORD_W = 8;

    typedef enum logic {
        FRAME_SHORT = 1'b0,
        FRAME_LONG  = 1'b1
    } frame_mode_e;

    typedef struct packed {
        logic bclk;
        logic fsync;
        logic rxd;
    } pin_sample_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } bclk_evt_t;

    // A pulse caught at two or more falls is long, otherwise short.
    function automatic frame_mode_e classify_width(input logic [1:0] hi_cnt);
        return (hi_cnt >= 2'd2) ? FRAME_LONG : FRAME_SHORT;
    endfunction

endpackage

// File: rtl/pcm_pin_sampler.sv
module pcm_pin_sampler
    import pcm_port_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bclk_i,
    input  logic      fsync_i,
    input  logic      rxd_i,
    output logic      fsync_s_o,
    output logic      rxd_s_o,
    output bclk_evt_t evt_o
);
    pin_sample_t stage_q [STAGES];
    logic        bclk_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
            bclk_prev_q <= 1'b0;
        end else begin
            stage_q[0] <= '{bclk: bclk_i, fsync: fsync_i, rxd: rxd_i};
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
            bclk_prev_q <= stage_q[STAGES-1].bclk;
        end
    end

    // All three pins move through the same stages, so they stay aligned.
    assign fsync_s_o  = stage_q[STAGES-1].fsync;
    assign rxd_s_o    = stage_q[STAGES-1].rxd;
    assign evt_o.rise = stage_q[STAGES-1].bclk & ~bclk_prev_q;
    assign evt_o.fall = ~stage_q[STAGES-1].bclk & bclk_prev_q;

endmodule

// File: rtl/pcm_sync_tracker.sv
module pcm_sync_tracker
    import pcm_port_pkg::*;
#(
    parameter int GUARD_FRAMES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwrdn_i,
    input  bclk_evt_t   evt_i,
    input  logic        fsync_s_i,
    output frame_mode_e mode_o,
    output logic        frame_rise_o,
    output logic        frame_tx_ok_o
);
    localparam int              CNT_W      = $clog2(GUARD_FRAMES + 1);
    localparam logic [CNT_W-1:0] GUARD_LAST = CNT_W'(GUARD_FRAMES);

    logic             fsync_at_rise_q;
    logic [1:0]       hi_cnt_q;
    frame_mode_e      mode_q;
    logic [CNT_W-1:0] guard_q;

    assign frame_rise_o  = evt_i.rise & fsync_s_i & ~fsync_at_rise_q;
    assign frame_tx_ok_o = (guard_q == GUARD_LAST);
    assign mode_o        = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsync_at_rise_q <= 1'b0;
            hi_cnt_q        <= '0;
            mode_q          <= FRAME_SHORT;
            guard_q         <= '0;
        end else begin
            if (evt_i.rise) fsync_at_rise_q <= fsync_s_i;

            // Width measurement; the verdict is used by the next frame.
            if (evt_i.fall) begin
                if (fsync_s_i) begin
                    if (hi_cnt_q != 2'd2) hi_cnt_q <= hi_cnt_q + 2'd1;
                end else if (hi_cnt_q != 2'd0) begin
                    mode_q   <= classify_width(hi_cnt_q);
                    hi_cnt_q <= '0;
                end
            end

            if (pwrdn_i)                            guard_q <= '0;
            else if (frame_rise_o && !frame_tx_ok_o) guard_q <= guard_q + 1'b1;
        end
    end

endmodule

// File: rtl/pcm_frame_engine.sv
module pcm_frame_engine
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = PCM_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwrdn_i,
    input  bclk_evt_t         evt_i,
    input  logic              fsync_s_i,
    input  logic              rxd_s_i,
    input  frame_mode_e       mode_i,
    input  logic              frame_rise_i,
    input  logic              frame_tx_ok_i,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic              txd_o,
    output logic              oe_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o
);
    localparam int IDX_W = $clog2(WORD_W);

    typedef struct packed {
        logic             active;
        logic             pending;
        logic             tx_ok;
        frame_mode_e      mode;
        logic [IDX_W-1:0] idx;
    } frame_state_t;

    frame_state_t      st_q;
    logic [WORD_W-1:0] tx_lat_q, rx_sh_q, rx_word_q;
    logic              oe_q, valid_q;
    logic              start, start_ok, last_bit;

    always_comb begin
        start    = evt_i.rise &&
                   ((frame_rise_i && mode_i == FRAME_LONG) || (!frame_rise_i && st_q.pending));
        start_ok = frame_rise_i ? frame_tx_ok_i : st_q.tx_ok;
        last_bit = (st_q.idx == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            tx_lat_q  <= '0;
            rx_sh_q   <= '0;
            rx_word_q <= '0;
            oe_q      <= 1'b0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (pwrdn_i) begin
                st_q.active  <= 1'b0;
                st_q.pending <= 1'b0;
                oe_q         <= 1'b0;
            end else if (evt_i.rise) begin
                if (frame_rise_i) begin
                    st_q.tx_ok   <= frame_tx_ok_i;
                    st_q.mode    <= mode_i;
                    st_q.pending <= (mode_i == FRAME_SHORT);
                end else begin
                    st_q.pending <= 1'b0;
                end
                if (start) begin
                    st_q.active <= 1'b1;
                    st_q.idx    <= IDX_W'(WORD_W - 1);
                    tx_lat_q    <= tx_word_i;
                    oe_q        <= start_ok;
                end else begin
                    if (st_q.active && !last_bit) st_q.idx <= st_q.idx - 1'b1;
                    // Long-frame hold ends at the first rise with sync low.
                    if (oe_q && !st_q.active && !fsync_s_i) oe_q <= 1'b0;
                end
            end else if (evt_i.fall && st_q.active) begin
                rx_sh_q <= {rx_sh_q[WORD_W-2:0], rxd_s_i};
                if (last_bit) begin
                    st_q.active <= 1'b0;
                    valid_q     <= 1'b1;
                    rx_word_q   <= {rx_sh_q[WORD_W-2:0], rxd_s_i};
                    if (st_q.mode == FRAME_SHORT || !fsync_s_i) oe_q <= 1'b0;
                end
            end
        end
    end

    assign txd_o      = oe_q & tx_lat_q[st_q.idx];
    assign oe_o       = oe_q;
    assign rx_word_o  = rx_word_q;
    assign rx_valid_o = valid_q;

endmodule

// File: rtl/pcm_fsync_port.sv
module pcm_fsync_port
    import pcm_port_pkg::*;
#(
    parameter int WORD_W       = PCM_WORD_W,
    parameter int SYNC_STAGES  = 2,
    parameter int GUARD_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk_i,
    input  logic              fsync_i,
    input  logic              rxd_i,
    input  logic              pwrdn_i,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic              txd_o,
    output logic              txd_oe_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o
);
    bclk_evt_t   bclk_evt;
    logic        fsync_s, rxd_s;
    frame_mode_e frame_mode;
    logic        frame_rise, frame_tx_ok;
    logic        bclk_rise, bclk_fall;

    assign bclk_rise = bclk_evt.rise;
    assign bclk_fall = bclk_evt.fall;

    pcm_pin_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst(rst), .bclk_i(bclk_i), .fsync_i(fsync_i), .rxd_i(rxd_i),
        .fsync_s_o(fsync_s), .rxd_s_o(rxd_s), .evt_o(bclk_evt)
    );

    pcm_sync_tracker #(.GUARD_FRAMES(GUARD_FRAMES)) u_tracker (
        .clk(clk), .rst(rst), .pwrdn_i(pwrdn_i), .evt_i(bclk_evt), .fsync_s_i(fsync_s),
        .mode_o(frame_mode), .frame_rise_o(frame_rise), .frame_tx_ok_o(frame_tx_ok)
    );

    pcm_frame_engine #(.WORD_W(WORD_W)) u_engine (
        .clk(clk), .rst(rst), .pwrdn_i(pwrdn_i), .evt_i(bclk_evt),
        .fsync_s_i(fsync_s), .rxd_s_i(rxd_s), .mode_i(frame_mode),
        .frame_rise_i(frame_rise), .frame_tx_ok_i(frame_tx_ok), .tx_word_i(tx_word_i),
        .txd_o(txd_o), .oe_o(txd_oe_o), .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o)
    );

endmodule

// File: rtl/pcm_fsync_port_checker.sv
module pcm_fsync_port_checker #(
    parameter int GUARD_FRAMES = 2
) (
    input logic clk,
    input logic rst,
    input logic pwrdn_i,
    input logic txd_o,
    input logic txd_oe_o,
    input logic rx_valid_o,
    input logic bclk_rise,
    input logic bclk_fall,
    input logic frame_rise
);
    localparam int            GW      = $clog2(GUARD_FRAMES + 2);
    localparam logic [GW-1:0] G_LIMIT = GW'(GUARD_FRAMES);

    logic [GW-1:0] seen_frames;

    always_ff @(posedge clk) begin
        if (rst || pwrdn_i)                           seen_frames <= '0;
        else if (frame_rise && seen_frames <= G_LIMIT) seen_frames <= seen_frames + 1'b1;
    end

    assert_oe_low_in_pwrdn_R8: assert property (@(posedge clk) disable iff (rst)
        pwrdn_i |=> !txd_oe_o);

    assert_no_strobe_in_pwrdn_R8: assert property (@(posedge clk) disable iff (rst)
        pwrdn_i |=> !rx_valid_o);

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    assert_oe_rise_on_bclk_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(txd_oe_o) |-> $past(bclk_rise));

    assert_oe_fall_on_edge_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(txd_oe_o) |-> ($past(bclk_fall) || $past(bclk_rise) || $past(pwrdn_i)));

    assert_txd_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(bclk_rise) && !$past(bclk_fall) && !$past(pwrdn_i)) |-> $stable(txd_o));

    assert_txd_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !txd_oe_o |-> !txd_o);

    assert_guard_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (seen_frames <= G_LIMIT) |-> !txd_oe_o);

endmodule

bind pcm_fsync_port pcm_fsync_port_checker #(.GUARD_FRAMES(GUARD_FRAMES)) u_checker (
    .clk(clk), .rst(rst), .pwrdn_i(pwrdn_i), .txd_o(txd_o), .txd_oe_o(txd_oe_o),
    .rx_valid_o(rx_valid_o), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .frame_rise(frame_rise)
);

// File: tb/pcm_fsync_port_bench.sv
`timescale 1ns/1ps
module pcm_fsync_port_bench;
    localparam int HALF       = 8;
    localparam int FRAME_BITS = 16;
    localparam int WDOG       = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bclk = 1'b0, fsync = 1'b0, rxd = 1'b0, pwrdn = 1'b0;
    logic [7:0] tx_word = '0;
    logic       txd_o, txd_oe_o, rx_valid_o;
    logic [7:0] rx_word_o;

    int         checks = 0, failures = 0;
    bit         prev_long = 1'b0;
    int         guard = 0;
    logic [7:0] exp_q [$];
    logic [7:0] exp_w;
    logic       valid_prev = 1'b0;

    always #2.5 clk = ~clk;

    pcm_fsync_port u_pcm_fsync_port (
        .clk(clk), .rst(rst), .bclk_i(bclk), .fsync_i(fsync), .rxd_i(rxd),
        .pwrdn_i(pwrdn), .tx_word_i(tx_word), .txd_o(txd_o), .txd_oe_o(txd_oe_o),
        .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bclk = 1'b1; fsync = 1'b0; rxd = 1'b0;
            repeat (HALF-1) @(negedge clk);
            chk("R10", "txd while idle", txd_o, 0);
            @(negedge clk); bclk = 1'b0;
            repeat (HALF-1) @(negedge clk);
        end
    endtask

    // Driver: pushes the expected receive word, then plays one frame and
    // checks the transmit side against the framing rules.
    task automatic run_frame(input int sync_len, input logic [7:0] rx_w,
                             input logic [7:0] tx_w, input string req);
        bit lng, en;
        int s;
        lng = prev_long;
        if (pwrdn) en = 1'b0;
        else begin
            en = (guard >= 2);
            if (guard < 2) guard++;
        end
        s = lng ? 0 : 1;
        tx_word = tx_w;
        if (!pwrdn) exp_q.push_back(rx_w);
        for (int i = 0; i < FRAME_BITS; i++) begin
            logic sv;
            int   b;
            bit   data_p, exp_hi, exp_lo;
            sv     = (i < sync_len);
            b      = i - s;
            data_p = (b >= 0 && b < 8);
            @(negedge clk); bclk = 1'b1; fsync = sv; rxd = data_p ? rx_w[7-b] : i[0];
            repeat (HALF-1) @(negedge clk);
            exp_hi = en && (data_p || (lng && sv && b > 7));
            chk(req, "oe in high phase", txd_oe_o, exp_hi);
            if (exp_hi && data_p) chk(req, "txd bit", txd_o, tx_w[7-b]);
            else if (!exp_hi)     chk("R10", "txd with oe low", txd_o, 0);
            @(negedge clk); bclk = 1'b0;
            repeat (HALF-1) @(negedge clk);
            exp_lo = en && ((b >= 0 && b <= 6) || (lng && sv && b >= 7));
            chk(req, "oe in low phase", txd_oe_o, exp_lo);
        end
        prev_long = (sync_len >= 2);
    endtask

    // Monitor: pops expected words as strobes appear.
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid_o && valid_prev)
                chk("R7", "strobe width over one cycle", 2, 1);
            if (rx_valid_o) begin
                if (exp_q.size() == 0) chk("R7", "unexpected strobe", 1, 0);
                else begin
                    exp_w = exp_q.pop_front();
                    chk("R6", "received word", rx_word_o, exp_w);
                end
            end
            valid_prev = rx_valid_o;
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (6) @(negedge clk);
        chk("R1", "oe in reset", txd_oe_o, 0);
        chk("R1", "txd in reset", txd_o, 0);
        chk("R1", "strobe in reset", rx_valid_o, 0);
        rst = 1'b0;
        idle(4);
        chk("R1", "oe after reset", txd_oe_o, 0);

        run_frame(1,  8'hA5, 8'h3C, "R1");  // guard frame 1, short framing
        run_frame(3,  8'h5A, 8'hC3, "R9");  // guard frame 2, pulse classed long
        run_frame(1,  8'h81, 8'hB4, "R5");  // long framing, short pulse
        run_frame(2,  8'h7E, 8'h96, "R3");  // short framing, long pulse
        run_frame(11, 8'h0F, 8'hE1, "R5");  // long framing with sync held past LSB
        run_frame(1,  8'hF0, 8'h1E, "R2");  // long framing chosen by previous pulse
        run_frame(1,  8'h33, 8'hCC, "R4");  // short framing

        pwrdn = 1'b1;
        guard = 0;
        idle(2);
        run_frame(1,  8'h99, 8'h66, "R8");  // whole frame in power-down
        idle(2);
        pwrdn = 1'b0;
        idle(1);
        run_frame(2,  8'h12, 8'h48, "R9");
        run_frame(1,  8'h34, 8'h2C, "R9");
        run_frame(1,  8'hC5, 8'hA3, "R3");  // first frame allowed after guard

        idle(3);
        chk("R7", "words left unreceived", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule